// File: doc/BRIEF.md
# Sampling Converter Serial Configuration and Result Port

This block is the digital front of a multiplexed sampling converter. It behaves as a four-wire full-duplex serial slave: an active-low chip select frames each exchange, a shift clock paces it, and data moves in both directions at once. During each frame the host shifts in an 8-bit configuration word that requests the next conversion. In the same frame the block shifts out the result of the conversion requested one frame earlier, formatted as that earlier word asked.

The configuration word carries a 4-bit multiplexer address, a polarity flag, a bit-order flag and a 2-bit length code. When the frame closes with a complete word, the block pulses a conversion-start strobe and presents the multiplexer address. The converter core, which is modelled only as ports, later returns a 12-bit raw code with a done strobe. The raw code is offset binary, so bipolar mode turns it into two's complement by inverting its top bit. All serial pins are sampled through synchronizers into the system clock domain, so the shift clock must stay well below the system clock.

Top module: `adc_link_top`

## Requirements
- R1: After reset, sdo and conv_start are low and mux_sel is 0. The stored result is zero with format unipolar, MSB first, 12 bits, so the first frame shifts out only zeros.
- R2: While chip select is high, sdo is driven low and shift-clock edges have no effect.
- R3: Only the first eight rising shift-clock edges of a frame load the configuration word, first bit into bit 7. Bits 7..4 are the multiplexer address, bit 3 selects unipolar (1) or bipolar (0), bit 2 selects MSB first (1) or LSB first (0), and bits 1..0 are the length code. Later sdi bits in the frame are ignored.
- R4: When chip select rises after a complete 8-bit word, conv_start pulses for exactly one system clock. In that same cycle mux_sel takes bits 7..4 of the word and then holds them until the next pulse.
- R5: A frame with fewer than eight rising shift-clock edges raises no conv_start and leaves mux_sel and the pending configuration unchanged.
- R6: The result shifted out in a frame is the one latched from the conversion requested by the previous complete frame. The first bit is on sdo before the first rising shift-clock edge, and each later bit appears after a falling edge.
- R7: Length code 01 or 00 sends the upper 8 result bits. Code 10 sends all 12 bits. Code 11 sends the 12 bits followed by four zeros.
- R8: In LSB-first order the lowest kept bit is sent first: B0 for the 12-bit and 16-bit codes, B4 for the 8-bit codes. Any padding follows.
- R9: In bipolar mode the top bit of the raw code is inverted before sending. In unipolar mode the code is sent unchanged.
- R10: A conv_done pulse latches conv_data together with the configuration that requested the conversion.
- R11: After the last result bit of the selected length, sdo stays low for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdi | input | 1 | Serial configuration data in |
| sdo | output | 1 | Serial result data out |
| conv_start | output | 1 | One-cycle conversion request strobe |
| mux_sel | output | 4 | Multiplexer address for the requested conversion |
| conv_done | input | 1 | One-cycle strobe from the converter core |
| conv_data | input | 12 | Raw offset-binary result from the core |

## Verification
The scoreboard runs a chain of frames, each changing polarity, bit order and length code relative to the one before. This shows that each outgoing word follows the configuration of the previous frame and not the current one. The raw codes are asymmetric (0xA5C, 0x3F1, 0x8F0, 0x123, 0x7FE) so that a swapped order, a wrong kept half, a lost top-bit inversion or missing padding each changes specific bit positions. After the eighth bit of every frame, sdi carries the inverted word, which exposes any loading past eight edges. A truncated five-edge frame must produce no start pulse and must leave mux_sel unchanged.

// File: rtl/adc_link_pkg.sv
// Package: shared constants, configuration layout and result formatting
// for the converter serial link. Assumes a 12-bit raw result in offset binary.
package adc_link_pkg;

    localparam int CFG_BITS   = 8;
    localparam int RES_BITS   = 12;
    localparam int FRAME_BITS = 16;
    localparam int MUX_BITS   = 4;
    localparam int SHORT_BITS = 8;

    typedef enum logic [1:0] {
        WL_SHORT_ALT = 2'b00,
        WL_SHORT     = 2'b01,
        WL_FULL      = 2'b10,
        WL_PADDED    = 2'b11
    } wlen_e;

    // Field order follows arrival order: first received bit is bit 7.
    typedef struct packed {
        logic [MUX_BITS-1:0] mux;
        logic                unipolar;
        logic                msb_first;
        wlen_e               wlen;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mux: '0, unipolar: 1'b1,
                                   msb_first: 1'b1, wlen: WL_FULL};

    // Number of result bits actually kept for a length code.
    function automatic int kept_bits(input wlen_e w);
        return ((w == WL_SHORT) || (w == WL_SHORT_ALT)) ? SHORT_BITS : RES_BITS;
    endfunction

    // Build the outgoing word, first bit to send at the top, zeros after.
    function automatic logic [FRAME_BITS-1:0] frame_word(
        input logic [RES_BITS-1:0] raw,
        input cfg_t                c
    );
        logic [RES_BITS-1:0]   code;
        logic [FRAME_BITS-1:0] w;
        int                    keep;
        code = raw;
        if (!c.unipolar) code[RES_BITS-1] = ~raw[RES_BITS-1];
        keep = kept_bits(c.wlen);
        w    = '0;
        for (int i = 0; i < RES_BITS; i++) begin
            if (i < keep) begin
                if (c.msb_first) w[FRAME_BITS-1-i] = code[RES_BITS-1-i];
                else             w[FRAME_BITS-1-i] = code[RES_BITS-keep+i];
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/adc_link_sync.sv
// Module: multi-bit synchronizer with edge detect.
// Brings N asynchronous pins into the clk domain through STAGES flops and
// flags single-cycle rising/falling edges of the synchronized level.
// Assumes each pin stays stable for several clk cycles between changes.
module adc_link_sync #(
    parameter int              N       = 3,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_async,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] pipe [STAGES+1];

    // First capture flop of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= pin_async;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            // Remaining chain flops, the last one holds the previous level.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/adc_link_cfg_rx.sv
// Module: configuration receiver.
// Shifts in sdi on the first CFG_BITS rising shift-clock edges of a frame,
// and on frame end issues a one-cycle start pulse and updates the pending
// configuration only if the word was complete.
// Assumes strobes are single-cycle and already synchronized.
module adc_link_cfg_rx
    import adc_link_pkg::*;
#(
    parameter int NBITS = CFG_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_act,
    input  logic frame_end,
    input  logic sclk_rise,
    input  logic sdi_lvl,
    output logic conv_start,
    output cfg_t req_cfg
);

    localparam int CNT_W = $clog2(NBITS + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [NBITS-1:0] shift_q;
    logic             word_full;

    assign word_full = (bit_cnt == CNT_W'(NBITS));

    // Count and capture configuration bits; idle at zero outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (!frame_act) begin
            bit_cnt <= '0;
        end else if (sclk_rise && !word_full) begin
            shift_q <= {shift_q[NBITS-2:0], sdi_lvl};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Issue the start strobe and commit the request on a complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            req_cfg    <= CFG_RESET;
        end else begin
            conv_start <= frame_end && word_full;
            if (frame_end && word_full) req_cfg <= cfg_t'(shift_q);
        end
    end

endmodule

// File: rtl/adc_link_result.sv
// Module: result store.
// Latches the raw converter code and the configuration that requested it
// when the core signals completion. Holds zero after reset.
module adc_link_result
    import adc_link_pkg::*;
#(
    parameter int RW = RES_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [RW-1:0] conv_data,
    input  cfg_t          req_cfg,
    output logic [RW-1:0] res_code,
    output cfg_t          res_cfg
);

    // Capture the finished conversion and its format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code <= '0;
            res_cfg  <= CFG_RESET;
        end else if (conv_done) begin
            res_code <= conv_data;
            res_cfg  <= req_cfg;
        end
    end

endmodule

// File: rtl/adc_link_tx.sv
// Module: result transmitter.
// Loads the formatted word at frame start so the first bit is ready before
// the first rising shift-clock edge, then advances on each falling edge.
// Drives zero outside a frame and after the last kept bit.
module adc_link_tx
    import adc_link_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_act,
    input  logic                frame_begin,
    input  logic                sclk_fall,
    input  logic [RES_BITS-1:0] res_code,
    input  cfg_t                res_cfg,
    output logic                sdo
);

    logic [FRAME_BITS-1:0] out_q;
    logic [FRAME_BITS-1:0] word_d;

    // Combinational formatting of the stored result.
    always_comb word_d = frame_word(res_code, res_cfg);

    // Load on frame start, shift on falling edges, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              out_q <= '0;
        else if (frame_begin)    out_q <= word_d;
        else if (!frame_act)     out_q <= '0;
        else if (sclk_fall)      out_q <= {out_q[FRAME_BITS-2:0], 1'b0};
    end

    assign sdo = frame_act & out_q[FRAME_BITS-1];

endmodule

// File: rtl/adc_link_top.sv
// Module: converter serial link top.
// Serial slave that takes a configuration word per chip-select frame,
// starts the requested conversion at frame end and returns the previous
// result in the format its request chose. Assumes sclk is slower than
// clk by enough margin for SYNC_STAGES+1 cycles per phase.
module adc_link_top
    import adc_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdi,
    output logic                sdo,
    output logic                conv_start,
    output logic [MUX_BITS-1:0] mux_sel,
    input  logic                conv_done,
    input  logic [RES_BITS-1:0] conv_data
);

    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_SDI  = 2;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic       frame_act;
    cfg_t       req_cfg, res_cfg;
    logic [RES_BITS-1:0] res_code;
    logic       sync_unused;

    adc_link_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({sdi, sclk, cs_n}),
        .level     (pin_lvl),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    assign frame_act   = ~pin_lvl[PIN_CS];
    assign sync_unused = ^{pin_lvl[PIN_SCLK], pin_rise[PIN_SDI], pin_fall[PIN_SDI]};

    adc_link_cfg_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_act  (frame_act),
        .frame_end  (pin_rise[PIN_CS]),
        .sclk_rise  (pin_rise[PIN_SCLK]),
        .sdi_lvl    (pin_lvl[PIN_SDI]),
        .conv_start (conv_start),
        .req_cfg    (req_cfg)
    );

    adc_link_result u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .req_cfg   (req_cfg),
        .res_code  (res_code),
        .res_cfg   (res_cfg)
    );

    adc_link_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_act   (frame_act),
        .frame_begin (pin_fall[PIN_CS]),
        .sclk_fall   (pin_fall[PIN_SCLK]),
        .res_code    (res_code),
        .res_cfg     (res_cfg),
        .sdo         (sdo)
    );

    assign mux_sel = req_cfg.mux;

endmodule

// File: rtl/adc_link_chk.sv
// Module: protocol checker for adc_link_top, attached by bind.
module adc_link_chk
    import adc_link_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                frame_act,
    input logic                sdo,
    input logic                conv_start,
    input logic [MUX_BITS-1:0] mux_sel,
    input logic                conv_done,
    input logic [RES_BITS-1:0] conv_data,
    input logic [RES_BITS-1:0] res_code
);

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4
    start_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !frame_act);

    // R4
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> conv_start);

    // R2
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |-> !sdo);

    // R10
    result_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (res_code == $past(conv_data)));

endmodule

bind adc_link_top adc_link_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_act  (frame_act),
    .sdo        (sdo),
    .conv_start (conv_start),
    .mux_sel    (mux_sel),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .res_code   (res_code)
);

// File: tb/test_adc_link_top.sv
// Scoreboard bench: the frame driver queues expected sdo bits and expected
// start addresses; monitors compare them as the design produces them.
module test_adc_link_top;

    localparam int HALF = 8;    // clk cycles per shift-clock phase
    localparam int CONV_LAT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        sdo, conv_start, conv_done = 1'b0;
    logic [3:0]  mux_sel;
    logic [11:0] conv_data = '0;

    int n_checks = 0, n_errors = 0;
    int starts_seen = 0, starts_exp = 0;

    typedef struct { logic val; string tag; } exp_t;
    exp_t       bit_q[$];
    logic [3:0] mux_q[$];

    // model state
    logic [11:0] m_raw = '0;
    logic [7:0]  m_fmt = 8'h0E;
    logic [7:0]  m_req = 8'h0E;
    logic [11:0] next_data = '0;
    int          conv_cnt = -1;
    logic        prev_start = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    adc_link_top i_adc_link_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .conv_start(conv_start), .mux_sel(mux_sel),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected i-th outgoing bit from requirements R7, R8, R9, R11.
    function automatic logic exp_bit(input logic [11:0] raw, input logic [7:0] c, input int i);
        logic [11:0] code;
        int nd;
        nd = (c[1:0] == 2'b10 || c[1:0] == 2'b11) ? 12 : 8;
        code = raw;
        if (!c[3]) code[11] = ~raw[11];
        if (i >= nd) return 1'b0;
        return c[2] ? code[11-i] : code[12-nd+i];
    endfunction

    // Bit monitor: sample sdo at each rising shift-clock edge inside a frame.
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (bit_q.size() == 0) check(1'b0, "R6 queue", 0, 1);
            else begin
                exp_t e;
                e = bit_q.pop_front();
                check(sdo === e.val, e.tag, sdo, e.val);
            end
        end
    end

    // Converter model and start monitor (R3, R4, R10).
    always @(negedge clk) begin
        if (conv_done) conv_done = 1'b0;
        if (rst_n && conv_start) begin
            starts_seen++;
            check(!prev_start, "R4 pulse width", 1, 0);
            if (mux_q.size() == 0) check(1'b0, "R4 unexpected start", 1, 0);
            else begin
                logic [3:0] em;
                em = mux_q.pop_front();
                check(mux_sel === em, "R3 R4 mux_sel", mux_sel, em);
            end
            conv_cnt = CONV_LAT;
        end else if (conv_cnt > 0) begin
            conv_cnt--;
        end else if (conv_cnt == 0) begin
            conv_data = next_data;
            conv_done = 1'b1;
            m_raw = next_data;
            m_fmt = m_req;
            conv_cnt = -1;
        end
        prev_start = conv_start;
    end

    task automatic run_frame(input logic [7:0] cfg, input int nclk,
                             input logic [11:0] data, input string tag);
        next_data = data;
        for (int i = 0; i < nclk; i++) begin
            exp_t e;
            e.val = exp_bit(m_raw, m_fmt, i);
            e.tag = (i >= ((m_fmt[1] == 1'b1) ? 12 : 8)) ? "R11" : tag;
            bit_q.push_back(e);
        end
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 8) ? cfg[7-i] : ~cfg[15-i];   // junk after eight bits
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (nclk >= 8) begin
            mux_q.push_back(cfg[7:4]);
            m_req = cfg;
            starts_exp++;
        end
        cs_n = 1'b1;
        repeat (2 * CONV_LAT) @(negedge clk);
        check(sdo === 1'b0, "R2 idle sdo", sdo, 0);
        check(starts_seen == starts_exp, (nclk < 8) ? "R5 start count" : "R4 start count",
              starts_seen, starts_exp);
        check(bit_q.size() == 0, "R6 bits consumed", bit_q.size(), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo === 1'b0, "R1 sdo", sdo, 0);
        check(conv_start === 1'b0, "R1 conv_start", conv_start, 0);
        check(mux_sel === 4'h0, "R1 mux_sel", mux_sel, 0);
        // sclk toggles with cs high must do nothing (R2)
        for (int i = 0; i < 3; i++) begin
            repeat (HALF) @(negedge clk); sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
        end
        check(sdo === 1'b0 && starts_seen == 0, "R2 idle edges", sdo, 0);

        run_frame(8'h3E, 16, 12'hA5C, "R1");   // first frame: zeros
        run_frame(8'hAD, 16, 12'h3F1, "R6");   // 0xA5C, 12 bits MSB first
        run_frame(8'h52, 16, 12'h8F0, "R7");   // 0x3F1, 8 bits
        run_frame(8'hF8, 16, 12'h123, "R9");   // 0x8F0 bipolar LSB first
        run_frame(8'h67, 16, 12'h7FE, "R8");   // 0x123 code 00 LSB first
        run_frame(8'h91,  5, 12'h000, "R5");   // truncated frame
        check(mux_sel === 4'h6, "R5 mux_sel kept", mux_sel, 6);
        run_frame(8'h3E, 16, 12'h555, "R7");   // 0x7FE bipolar 16 bits
        run_frame(8'h0E, 16, 12'h000, "R10");  // 0x555 unipolar 12 bits

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule